// File: doc/BRIEF.md
# Table-free parallel bit interleaver

This block is the interleaver between two constituent decoders of an iterative decoder. It keeps no permutation table. Each interleaved position is produced by logic while the block runs. The permutation is the quadratic map f(i) = (F1·i + F2·i²) mod N. It is stepped forward by incremental modular adds, so the full polynomial is never evaluated. The frame of N values is held in M storage banks, where M is the number of bits carried by one modulation symbol.

A `start` pulse opens a frame. On each `wr_vld` cycle the block takes M values, one per lane, and writes all of them in the same cycle, each into its own bank. On each `rd_en` cycle it fetches M values in interleaved order, one from every bank, and routes them to the output lanes through a crossbar. `F1` must be coprime to M and `F2` must be a multiple of M. With these settings any M consecutive permuted addresses land in M different banks, so reads never collide. The coefficients are checked when the design is elaborated.

Top module: `bilv_top`

## Requirements
- R1: While reset is held and after it is released, `rd_vld` and `done` are low until a read is issued.
- R2: Lane k of the j-th accepted write group after `start` (counting from 0) is stored as linear frame position j·M+k. Lane k occupies bits [k·W +: W] of `wr_data`.
- R3: Lane k (bits [k·W +: W] of `rd_data`) of the r-th read group after `start` carries the value stored at position f(r·M+k), where f(i) = (F1·i + F2·i²) mod N.
- R4: `rd_vld` is high exactly one cycle after an accepted `rd_en` cycle, and low otherwise.
- R5: `done` is high for exactly one cycle, alongside the `rd_vld` of read group N/M−1.
- R6: `rd_en` has no effect before the first `start` and after N/M read groups, until the next `start`.
- R7: `wr_vld` cycles beyond the first N/M after `start` are ignored and leave the stored frame unchanged.
- R8: Every accepted read cycle addresses each of the M banks exactly once.
- R9: A `start` pulse, including one in the middle of a read, restarts both the write and read sequences from position 0 and the permutation from f(0) = 0. It leaves stored data in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Frame start pulse |
| wr_vld | input | 1 | Write strobe for one group of M values |
| wr_data | input | M·W | M write lanes, lane k at [k·W +: W] |
| rd_en | input | 1 | Request one interleaved read group |
| rd_data | output | M·W | M interleaved read lanes |
| rd_vld | output | 1 | `rd_data` holds a valid group |
| done | output | 1 | Final read group of the frame is on `rd_data` |

## Verification
The assertions check on every cycle that each accepted read touches every bank exactly once. They also check the one-cycle link between an accepted read and `rd_vld`, that `done` is a single-cycle pulse riding on a valid group, that the write count stays within the frame, and that the recursion returns to zero after `start`. Only the bench scenarios can show that the lane values follow the quadratic map, that writes land at the right positions, and that reads before `start`, reads after completion and surplus writes leave no trace. The bench also covers a restart in the middle of a read and reads issued with gaps.

// File: rtl/bilv_pkg.sv
package bilv_pkg;

  // Greatest common divisor for elaboration-time parameter checks.
  function automatic int unsigned gcd_u(input int unsigned a_in, input int unsigned b_in);
    int unsigned a;
    int unsigned b;
    int unsigned t;
    a = a_in;
    b = b_in;
    for (int n = 0; n < 64; n++) begin
      if (b != 0) begin
        t = a % b;
        a = b;
        b = t;
      end
    end
    return a;
  endfunction

endpackage

// File: rtl/bilv_addr_step.sv
// Advances the quadratic permutation recursion M steps per cycle and
// exposes the M intermediate addresses as read lanes.
module bilv_addr_step #(
  parameter int N  = 64,
  parameter int M  = 4,
  parameter int F2 = 8,
  localparam int AW = $clog2(N)
) (
  input  logic [AW-1:0]        f_q,
  input  logic [AW-1:0]        g_q,
  output logic [M-1:0][AW-1:0] lane_addr,
  output logic [AW-1:0]        f_nx,
  output logic [AW-1:0]        g_nx
);

  localparam logic [AW:0]   NV  = (AW+1)'(N);
  localparam logic [AW-1:0] DLT = AW'((2 * F2) % N);

  function automatic logic [AW-1:0] mod_add(input logic [AW-1:0] a, input logic [AW-1:0] b);
    logic [AW:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= NV) s = s - NV;
    return s[AW-1:0];
  endfunction

  logic [M:0][AW-1:0] fc;
  logic [M:0][AW-1:0] gc;

  assign fc[0] = f_q;
  assign gc[0] = g_q;

  for (genvar k = 0; k < M; k++) begin : g_step
    assign fc[k+1]      = mod_add(fc[k], gc[k]);
    assign gc[k+1]      = mod_add(gc[k], DLT);
    assign lane_addr[k] = fc[k];
  end

  assign f_nx = fc[M];
  assign g_nx = gc[M];

endmodule

// File: rtl/bilv_bank.sv
// One storage bank: single write port, registered read port.
module bilv_bank #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int RW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [RW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic          re,
  input  logic [RW-1:0] ra,
  output logic [W-1:0]  rq
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  always_ff @(posedge clk) begin
    if (re) rq <= mem[ra];
  end

endmodule

// File: rtl/bilv_xbar.sv
// Routes bank outputs to read lanes by the registered bank index of each lane.
module bilv_xbar #(
  parameter int M  = 4,
  parameter int W  = 8,
  parameter int BW = 2
) (
  input  logic [M-1:0][W-1:0]  bank_q,
  input  logic [M-1:0][BW-1:0] sel,
  output logic [M-1:0][W-1:0]  lane_q
);

  for (genvar k = 0; k < M; k++) begin : g_lane
    assign lane_q[k] = bank_q[sel[k]];
  end

endmodule

// File: rtl/bilv_top.sv
module bilv_top #(
  parameter int N  = 64,
  parameter int M  = 4,
  parameter int W  = 8,
  parameter int F1 = 3,
  parameter int F2 = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         wr_vld,
  input  logic [M*W-1:0] wr_data,
  input  logic         rd_en,
  output logic [M*W-1:0] rd_data,
  output logic         rd_vld,
  output logic         done
);

  localparam int ROWS = N / M;
  localparam int AW   = $clog2(N);
  localparam int RW   = $clog2(ROWS);
  localparam int BW   = (M > 1) ? $clog2(M) : 1;
  localparam int unsigned GCD1 = bilv_pkg::gcd_u(F1 % M, M);
  localparam logic [AW-1:0] G0 = AW'((F1 + F2) % N);
  localparam logic [RW:0]   ROWS_V = (RW+1)'(ROWS);
  localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

  if ((N % M != 0) || (F2 % M != 0) || (GCD1 != 1) || (ROWS < 2) || (M < 2)) begin : g_bad_cfg
    $error("bilv_top: N must be a multiple of M, F2 a multiple of M, F1 coprime to M");
  end

  // Reset: asynchronous assert, synchronous release
  logic rst_meta;
  logic rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  // Control state
  logic [RW:0]   wr_cnt_q, wr_cnt_d;
  logic [RW-1:0] rd_cnt_q, rd_cnt_d;
  logic          rd_open_q, rd_open_d;
  logic [AW-1:0] f_q, f_d, g_q, g_d;
  logic          vld_q, vld_d;
  logic          done_q, done_d;
  logic          wr_go, rd_go, rd_last;

  assign wr_go   = wr_vld && (wr_cnt_q < ROWS_V) && !start;
  assign rd_go   = rd_en && rd_open_q && !start;
  assign rd_last = (rd_cnt_q == LAST_ROW);

  // Address generation
  logic [M-1:0][AW-1:0] lane_addr;
  logic [AW-1:0]        f_nx, g_nx;
  logic [M-1:0][BW-1:0] lane_bank;
  logic [M-1:0][RW-1:0] lane_row;
  logic [M-1:0][RW-1:0] bank_row;
  logic [M-1:0][BW-1:0] sel_q;

  bilv_addr_step #(.N(N), .M(M), .F2(F2)) u_step (
    .f_q       (f_q),
    .g_q       (g_q),
    .lane_addr (lane_addr),
    .f_nx      (f_nx),
    .g_nx      (g_nx)
  );

  for (genvar k = 0; k < M; k++) begin : g_map
    assign lane_bank[k] = BW'(32'(lane_addr[k]) % M);
    assign lane_row[k]  = RW'(32'(lane_addr[k]) / M);
  end

  // Each bank takes the row of the lane that maps onto it
  always_comb begin
    bank_row = '0;
    for (int k = 0; k < M; k++) begin
      bank_row[lane_bank[k]] = lane_row[k];
    end
  end

  // Next-state logic
  always_comb begin
    wr_cnt_d  = wr_cnt_q;
    rd_cnt_d  = rd_cnt_q;
    rd_open_d = rd_open_q;
    f_d       = f_q;
    g_d       = g_q;
    if (start) begin
      wr_cnt_d  = '0;
      rd_cnt_d  = '0;
      rd_open_d = 1'b1;
      f_d       = '0;
      g_d       = G0;
    end else begin
      if (wr_go) wr_cnt_d = wr_cnt_q + 1'b1;
      if (rd_go) begin
        rd_cnt_d = rd_cnt_q + 1'b1;
        f_d      = f_nx;
        g_d      = g_nx;
        if (rd_last) rd_open_d = 1'b0;
      end
    end
    vld_d  = rd_go;
    done_d = rd_go && rd_last;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      wr_cnt_q  <= '0;
      rd_cnt_q  <= '0;
      rd_open_q <= 1'b0;
      f_q       <= '0;
      g_q       <= G0;
      vld_q     <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      wr_cnt_q  <= wr_cnt_d;
      rd_cnt_q  <= rd_cnt_d;
      rd_open_q <= rd_open_d;
      f_q       <= f_d;
      g_q       <= g_d;
      vld_q     <= vld_d;
      done_q    <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)     sel_q <= '0;
    else if (rd_go) sel_q <= lane_bank;
  end

  // Storage banks
  logic [M-1:0][W-1:0] bank_q;
  logic [M-1:0][W-1:0] lane_q;

  for (genvar b = 0; b < M; b++) begin : g_bank
    bilv_bank #(.DEPTH(ROWS), .W(W)) u_bank (
      .clk (clk),
      .we  (wr_go),
      .wa  (wr_cnt_q[RW-1:0]),
      .wd  (wr_data[b*W +: W]),
      .re  (rd_go),
      .ra  (bank_row[b]),
      .rq  (bank_q[b])
    );
  end

  bilv_xbar #(.M(M), .W(W), .BW(BW)) u_xbar (
    .bank_q (bank_q),
    .sel    (sel_q),
    .lane_q (lane_q)
  );

  assign rd_data = lane_q;
  assign rd_vld  = vld_q;
  assign done    = done_q;

endmodule

// File: rtl/bilv_chk.sv
module bilv_chk #(
  parameter int N = 64,
  parameter int M = 4,
  localparam int ROWS = N / M,
  localparam int AW   = $clog2(N),
  localparam int RW   = $clog2(ROWS),
  localparam int BW   = (M > 1) ? $clog2(M) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          rd_en,
  input logic          rd_go,
  input logic          rd_vld,
  input logic          done,
  input logic [RW:0]   wr_cnt_q,
  input logic [AW-1:0] f_q,
  input logic [M*BW-1:0] lane_bank
);

  logic [M-1:0] hit;
  always_comb begin
    hit = '0;
    for (int k = 0; k < M; k++) hit[lane_bank[k*BW +: BW]] = 1'b1;
  end

  a_r4_vld_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld |-> $past(rd_go));
  a_r4_issue_gives_vld: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> rd_vld);
  a_r5_done_with_vld: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> rd_vld);
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_go_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |-> rd_en);
  a_r7_wr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt_q <= (RW+1)'(ROWS));
  a_r8_banks_distinct: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |-> (hit == '1));
  a_r9_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (f_q == '0));

endmodule

bind bilv_top bilv_chk #(.N(N), .M(M)) u_chk (
  .clk       (clk),
  .rst_n     (rst_s),
  .start     (start),
  .rd_en     (rd_en),
  .rd_go     (rd_go),
  .rd_vld    (rd_vld),
  .done      (done),
  .wr_cnt_q  (wr_cnt_q),
  .f_q       (f_q),
  .lane_bank (lane_bank)
);

// File: tb/sim_bilv_top.sv
module sim_bilv_top;
  localparam int N = 64, M = 4, W = 8, F1 = 3, F2 = 8;
  localparam int ROWS = N / M;

  logic clk = 1'b0;
  logic rst_n, start, wr_vld, rd_en;
  logic [M*W-1:0] wr_data, rd_data;
  logic rd_vld, done;

  int checks = 0;
  int errors = 0;
  int perm [N];
  logic [W-1:0] stored [N];

  always #4 clk = ~clk;

  bilv_top #(.N(N), .M(M), .W(W), .F1(F1), .F2(F2)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_vld(wr_vld), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rd_vld(rd_vld), .done(done)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  // R2/R7: write one frame, optionally followed by a surplus group
  task automatic write_frame(input int salt, input bit extra);
    for (int r = 0; r < ROWS; r++) begin
      @(negedge clk);
      wr_vld = 1'b1;
      for (int k = 0; k < M; k++) begin
        wr_data[k*W +: W] = W'((r*M + k) * 5 + salt);
        stored[r*M + k]   = W'((r*M + k) * 5 + salt);
      end
    end
    if (extra) begin
      @(negedge clk);
      for (int k = 0; k < M; k++) wr_data[k*W +: W] = W'(8'hA5 ^ k);
    end
    @(negedge clk) wr_vld = 1'b0;
  endtask

  // R3/R4/R5: issue up to 'limit' read groups, with gaps if requested
  task automatic read_frame(input bit gaps, input int limit);
    int issued = 0;
    bit pend = 0;
    int grp = 0;
    for (int c = 0; c < 4*ROWS + 8; c++) begin
      @(negedge clk);
      if (pend) begin
        chk("R4 rd_vld high after issue", rd_vld, 1);
        for (int k = 0; k < M; k++)
          chk("R3 lane value", rd_data[k*W +: W], stored[perm[grp*M + k]]);
        chk("R5 done timing", done, (grp == ROWS-1));
      end else begin
        chk("R4 rd_vld low without issue", rd_vld, 0);
        chk("R5 done low", done, 0);
      end
      if (issued >= limit && !pend) begin
        rd_en = 1'b0;
        break;
      end
      rd_en = (issued < limit) && (!gaps || (c % 3 != 1));
      pend  = rd_en;
      grp   = issued;
      if (rd_en) issued++;
    end
  endtask

  task automatic idle_reads(input string req);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk) rd_en = 1'b1;
      @(negedge clk);
      chk(req, rd_vld, 0);
    end
    rd_en = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; wr_vld = 1'b0; rd_en = 1'b0; wr_data = '0;

    // Closed-form permutation and bijection check
    begin
      bit seen [N];
      int hits = 0;
      for (int i = 0; i < N; i++) seen[i] = 1'b0;
      for (int i = 0; i < N; i++) begin
        perm[i] = (F1*i + F2*i*i) % N;
        if (!seen[perm[i]]) hits++;
        seen[perm[i]] = 1'b1;
      end
      chk("R3 permutation is a bijection", hits, N);
    end

    repeat (3) @(negedge clk);
    chk("R1 rd_vld in reset", rd_vld, 0);
    chk("R1 done in reset", done, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 rd_vld after reset", rd_vld, 0);
    chk("R1 done after reset", done, 0);

    idle_reads("R6 read before start ignored");

    // Frame 1: reads with gaps
    pulse_start();
    write_frame(8'h11, 1'b0);
    read_frame(1'b1, ROWS);
    idle_reads("R6 read after done ignored");

    // Frame 2: surplus write must not disturb the frame (R7)
    pulse_start();
    write_frame(8'h40, 1'b1);
    read_frame(1'b0, ROWS);

    // R9: restart in the middle of a read
    pulse_start();
    write_frame(8'h77, 1'b0);
    read_frame(1'b0, 5);
    pulse_start();
    read_frame(1'b1, ROWS);
    idle_reads("R6 read after restarted frame ignored");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule